// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the processor-facing side of a four-channel DMA controller. A host reaches it over an 8-bit data bus with a 4-bit register index and separate read and write strobes. Each channel has a 16-bit base address word and a 16-bit count word. Both words move one byte per access, and a single low/high byte pointer is shared by all eight words. The block also holds a mask bit, a request bit, a transfer-complete flag and a 6-bit mode field for each channel, plus one global 8-bit command register. Some write indices act as commands and ignore the data: clear the byte pointer, master reset and unmask all channels.

The transfer engine outside this block reads the per-channel mask, request and mode fields and the command bits. It reports the end of a block transfer by pulsing the channel's terminal-count input. The host learns of completions by reading a status byte, and that read clears the completion flags.

Top module: `dmac_regfile`

## Requirements
- R1: After synchronous reset all four masks read 1, all request and transfer-complete flags are 0, the command register and every mode field are 0, every address and count word is 0, and the byte pointer selects the low byte.
- R2: Indices 0 to 7 reach the 16-bit words. Index bits [2:1] give the channel, and index bit 0 set selects the count word instead of the address word. Successive accesses move the low byte first and then the high byte, and reads return the bytes in the same order.
- R3: Every read or write of indices 0 to 7 toggles one byte pointer that all eight words share. A write and a read in the same cycle count as one access, and the write takes effect.
- R4: A write to index 0xC returns the byte pointer to the low byte.
- R5: A write to index 8 loads the 8-bit command register, which appears unchanged on cmd_out one cycle later.
- R6: A write to index 9 sets chan_req[d[1:0]] to d[2]. With no write strobe, request, mask and command outputs do not change.
- R7: A write to index 0xA sets chan_mask[d[1:0]] to d[2] and leaves the other masks as they were.
- R8: A write to index 0xB loads d[7:2] into the mode field of channel d[1:0]. On chan_mode, channel n occupies bits [6n+5:6n], and d[7:2] maps to those bits in order.
- R9: A write to index 0xF loads chan_mask[n] from d[n] for all four channels. A write to index 0xE clears all four masks.
- R10: A write to index 0xD sets all masks, clears every request and transfer-complete flag, and returns the byte pointer to low. The address and count words keep their values.
- R11: A read of index 8 returns {request[3:0], complete[3:0]} (request in bits [7:4]). All completion flags are 0 after that read.
- R12: A high bit of tc_in sets the matching completion flag. If it coincides with a status read, the set wins and the flag is 1 afterwards.
- R13: Reads of indices 9 to 0xF return 0xFF. Index 0xD stands for the temporary register, which always reads as 0xFF. These reads leave the byte pointer and the flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| reg_idx | input | 4 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current index (combinational) |
| tc_in | input | 4 | Per-channel terminal-count pulse |
| chan_mask | output | 4 | Per-channel mask bits |
| chan_req | output | 4 | Per-channel software request bits |
| chan_mode | output | 24 | Per-channel mode fields, 6 bits each |
| cmd_out | output | 8 | Command register |

## Verification
The 16-bit words are exercised in three ways. Clean low/high pairs show the channel and word decode. An access to one word followed by an access to another shows that the pointer is shared rather than kept per register. A pointer-clear between half-written accesses tells a working clear from a missing one. The byte-wide command writes use different bit patterns, so that single-channel updates, whole-vector updates and clear-all stay distinguishable. Status reads are made with a completion pulse that comes before the read and with one that arrives in the same cycle, so that clear-on-read and the set-wins rule are separated. Reads of indices with no data are placed between pointer-sensitive accesses, so that any stray toggle or flag clear shows up.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int NUM_CH   = 4;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int IDX_W    = 4;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int MODE_W   = 6;

    localparam logic [IDX_W-1:0] IX_CMD     = 4'h8;
    localparam logic [IDX_W-1:0] IX_STATUS  = 4'h8;
    localparam logic [IDX_W-1:0] IX_REQ     = 4'h9;
    localparam logic [IDX_W-1:0] IX_MASK1   = 4'hA;
    localparam logic [IDX_W-1:0] IX_MODE    = 4'hB;
    localparam logic [IDX_W-1:0] IX_PTRCLR  = 4'hC;
    localparam logic [IDX_W-1:0] IX_MRESET  = 4'hD;
    localparam logic [IDX_W-1:0] IX_UNMASK  = 4'hE;
    localparam logic [IDX_W-1:0] IX_MASKALL = 4'hF;

    typedef struct packed {
        logic [1:0] op_kind;
        logic       step_down;
        logic       auto_reload;
        logic [1:0] xfer_kind;
    } chan_mode_t;

    typedef struct packed {
        logic ack_high;
        logic req_low;
        logic ext_write;
        logic rotate_prio;
        logic short_timing;
        logic enable;
        logic ch0_hold;
        logic mem2mem;
    } cmd_reg_t;

    function automatic logic [WORD_W-1:0] put_byte(
        input logic [WORD_W-1:0] word,
        input logic              hi,
        input logic [BYTE_W-1:0] b
    );
        logic [WORD_W-1:0] r;
        r = word;
        if (hi) r[WORD_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]      = b;
        return r;
    endfunction

endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic clear,
    output logic hi_sel
);
    always_ff @(posedge clk) begin
        if (rst || clear) hi_sel <= 1'b0;
        else if (step)    hi_sel <= ~hi_sel;
    end

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> (hi_sel != $past(hi_sel)));
    p_ptr_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clear |=> !hi_sel);
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              addr_wr,
    input  logic              cnt_wr,
    input  logic              req_wr,
    input  logic              req_val,
    input  logic              mask_wr,
    input  logic              mask_val,
    input  logic              unmask_all,
    input  logic              mode_wr,
    input  chan_mode_t        mode_val,
    input  logic              mreset,
    input  logic              tc_set,
    input  logic              tc_clr,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] cnt_q,
    output logic              mask_q,
    output logic              req_q,
    output logic              tc_q,
    output chan_mode_t        mode_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
        end else begin
            if (addr_wr) addr_q <= put_byte(addr_q, hi_sel, wdata);
            if (cnt_wr)  cnt_q  <= put_byte(cnt_q, hi_sel, wdata);
            if (mode_wr) mode_q <= mode_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mreset)   mask_q <= 1'b1;
        else if (unmask_all) mask_q <= 1'b0;
        else if (mask_wr)    mask_q <= mask_val;
    end

    always_ff @(posedge clk) begin
        if (rst || mreset) req_q <= 1'b0;
        else if (req_wr)   req_q <= req_val;
    end

    always_ff @(posedge clk) begin
        if (rst)                  tc_q <= 1'b0;
        else if (tc_set)          tc_q <= 1'b1;
        else if (tc_clr || mreset) tc_q <= 1'b0;
    end

    p_tc_set_r12: assert property (@(posedge clk) disable iff (rst)
        tc_set |=> tc_q);
    p_mreset_r10: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (mask_q && !req_q));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_regs_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         reg_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [BYTE_W-1:0]        rd_data,
    input  logic [NUM_CH-1:0]        tc_in,
    output logic [NUM_CH-1:0]        chan_mask,
    output logic [NUM_CH-1:0]        chan_req,
    output logic [NUM_CH*MODE_W-1:0] chan_mode,
    output logic [BYTE_W-1:0]        cmd_out
);
    logic              rd_cyc, word_sel, is_cnt, stat_rd, hi_sel;
    logic [CH_W-1:0]   ch_idx;
    logic [NUM_CH-1:0] tc_v;
    logic [WORD_W-1:0] addr_a [NUM_CH];
    logic [WORD_W-1:0] cnt_a  [NUM_CH];
    logic [WORD_W-1:0] sel_word;
    cmd_reg_t          cmd_q;

    assign rd_cyc   = rd_en && !wr_en;
    assign word_sel = !reg_idx[IDX_W-1];
    assign is_cnt   = reg_idx[0];
    assign ch_idx   = reg_idx[CH_W:1];
    assign stat_rd  = rd_cyc && (reg_idx == IX_STATUS);

    dmac_byte_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .step   ((wr_en || rd_cyc) && word_sel),
        .clear  (wr_en && (reg_idx == IX_PTRCLR || reg_idx == IX_MRESET)),
        .hi_sel (hi_sel)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic       pick;
        chan_mode_t mode_n;
        assign pick = (wr_data[CH_W-1:0] == CH_W'(n));

        dmac_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .hi_sel     (hi_sel),
            .wdata      (wr_data),
            .addr_wr    (wr_en && word_sel && ch_idx == CH_W'(n) && !is_cnt),
            .cnt_wr     (wr_en && word_sel && ch_idx == CH_W'(n) && is_cnt),
            .req_wr     (wr_en && reg_idx == IX_REQ && pick),
            .req_val    (wr_data[2]),
            .mask_wr    (wr_en && ((reg_idx == IX_MASK1 && pick) || reg_idx == IX_MASKALL)),
            .mask_val   ((reg_idx == IX_MASKALL) ? wr_data[n] : wr_data[2]),
            .unmask_all (wr_en && reg_idx == IX_UNMASK),
            .mode_wr    (wr_en && reg_idx == IX_MODE && pick),
            .mode_val   (chan_mode_t'(wr_data[BYTE_W-1:2])),
            .mreset     (wr_en && reg_idx == IX_MRESET),
            .tc_set     (tc_in[n]),
            .tc_clr     (stat_rd),
            .addr_q     (addr_a[n]),
            .cnt_q      (cnt_a[n]),
            .mask_q     (chan_mask[n]),
            .req_q      (chan_req[n]),
            .tc_q       (tc_v[n]),
            .mode_q     (mode_n)
        );
        assign chan_mode[n*MODE_W +: MODE_W] = mode_n;
    end

    always_ff @(posedge clk) begin
        if (rst)                             cmd_q <= '0;
        else if (wr_en && reg_idx == IX_CMD) cmd_q <= cmd_reg_t'(wr_data);
    end
    assign cmd_out = cmd_q;

    always_comb begin
        sel_word = is_cnt ? cnt_a[ch_idx] : addr_a[ch_idx];
        rd_data  = 8'hFF;
        if (word_sel)
            rd_data = hi_sel ? sel_word[WORD_W-1:BYTE_W] : sel_word[BYTE_W-1:0];
        else if (reg_idx == IX_STATUS)
            rd_data = BYTE_W'({chan_req, tc_v});
    end

    p_cmd_load_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == IX_CMD) |=> (cmd_out == $past(wr_data)));
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(chan_req) && $stable(chan_mask) && $stable(cmd_out)));
    p_unmask_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == IX_UNMASK) |=> (chan_mask == '0));
    p_status_clear_r11: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> ((tc_v & ~$past(tc_in)) == '0));
    p_noread_ff_r13: assert property (@(posedge clk) disable iff (rst)
        (rd_cyc && reg_idx > IX_STATUS) |-> (rd_data == 8'hFF));
endmodule

// File: tb/dmac_regfile_tb.sv
module dmac_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  tc_in = '0;
    logic [3:0]  chan_mask, chan_req;
    logic [23:0] chan_mode;
    logic [7:0]  cmd_out;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    logic [7:0] rv;

    always #2.5 clk = ~clk;

    dmac_regfile u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
        .wr_data(wr_data), .rd_data(rd_data), .tc_in(tc_in), .chan_mask(chan_mask),
        .chan_req(chan_req), .chan_mode(chan_mode), .cmd_out(cmd_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            misses = misses + 1;
            $display("FAIL watchdog: got %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] ix, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = ix; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ix, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = ix;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_tc(input logic [3:0] v);
        @(negedge clk);
        tc_in = v;
        @(negedge clk);
        tc_in = '0;
    endtask

    task automatic t_reset;
        check("R1 mask", 32'(chan_mask), 32'hF);
        check("R1 req", 32'(chan_req), 32'h0);
        check("R1 mode", 32'(chan_mode), 32'h0);
        check("R1 cmd", 32'(cmd_out), 32'h0);
        rd(4'h0, rv); check("R1 word low", 32'(rv), 32'h0);
        rd(4'h0, rv); check("R1 word high", 32'(rv), 32'h0);
        rd(4'h8, rv); check("R1 status", 32'(rv), 32'h0);
    endtask

    task automatic t_words;
        wr(4'h4, 8'h34); wr(4'h4, 8'h12);
        wr(4'h3, 8'hCD); wr(4'h3, 8'hAB);
        wr(4'h7, 8'h5A); wr(4'h7, 8'hA5);
        rd(4'h4, rv); check("R2 ch2 addr lo", 32'(rv), 32'h34);
        rd(4'h4, rv); check("R2 ch2 addr hi", 32'(rv), 32'h12);
        rd(4'h3, rv); check("R2 ch1 cnt lo", 32'(rv), 32'hCD);
        rd(4'h3, rv); check("R2 ch1 cnt hi", 32'(rv), 32'hAB);
        rd(4'h7, rv); check("R2 ch3 cnt lo", 32'(rv), 32'h5A);
        rd(4'h7, rv); check("R2 ch3 cnt hi", 32'(rv), 32'hA5);
    endtask

    task automatic t_shared;
        wr(4'h0, 8'h11);
        wr(4'h1, 8'h22);
        rd(4'h1, rv); check("R3 shared ptr lo", 32'(rv), 32'h00);
        rd(4'h1, rv); check("R3 shared ptr hi", 32'(rv), 32'h22);
        wr(4'h0, 8'h11);
        wr(4'hC, 8'h00);
        rd(4'h0, rv); check("R4 ptr clear", 32'(rv), 32'h11);
        wr(4'hC, 8'h00);
    endtask

    task automatic t_cmd;
        wr(4'h8, 8'hA5); check("R5 cmd A5", 32'(cmd_out), 32'hA5);
        wr(4'h8, 8'h5A); check("R5 cmd 5A", 32'(cmd_out), 32'h5A);
    endtask

    task automatic t_req;
        wr(4'h9, 8'h06); check("R6 req set ch2", 32'(chan_req), 32'h4);
        wr(4'h9, 8'h05); check("R6 req set ch1", 32'(chan_req), 32'h6);
        wr(4'h9, 8'h02); check("R6 req clr ch2", 32'(chan_req), 32'h2);
        rd(4'h8, rv); check("R11 status req field", 32'(rv), 32'h20);
    endtask

    task automatic t_mask;
        wr(4'hE, 8'hFF); check("R9 unmask all", 32'(chan_mask), 32'h0);
        wr(4'hA, 8'h07); check("R7 mask ch3", 32'(chan_mask), 32'h8);
        wr(4'hA, 8'h04); check("R7 mask ch0", 32'(chan_mask), 32'h9);
        wr(4'hA, 8'h03); check("R7 unmask ch3", 32'(chan_mask), 32'h1);
        wr(4'hF, 8'h0A); check("R9 mask all 0A", 32'(chan_mask), 32'hA);
        wr(4'hF, 8'hF5); check("R9 mask all F5", 32'(chan_mask), 32'h5);
    endtask

    task automatic t_mode;
        wr(4'hB, 8'hE9); check("R8 mode ch1", 32'(chan_mode), 32'hE80);
        wr(4'hB, 8'h14); check("R8 mode ch0", 32'(chan_mode), 32'hE85);
    endtask

    task automatic t_status;
        pulse_tc(4'h5);
        rd(4'h8, rv); check("R11 status tc", 32'(rv), 32'h25);
        rd(4'h8, rv); check("R11 tc cleared", 32'(rv), 32'h20);
        @(negedge clk);
        rd_en = 1'b1; reg_idx = 4'h8; tc_in = 4'h2;
        #1 rv = rd_data;
        @(negedge clk);
        rd_en = 1'b0; tc_in = '0;
        check("R12 read during set", 32'(rv), 32'h20);
        rd(4'h8, rv); check("R12 set wins", 32'(rv), 32'h22);
        rd(4'h8, rv); check("R11 cleared after", 32'(rv), 32'h20);
    endtask

    task automatic t_noread;
        pulse_tc(4'h8);
        wr(4'h0, 8'h77);
        for (int i = 9; i < 16; i++) begin
            rd(4'(i), rv); check("R13 no-data read", 32'(rv), 32'hFF);
        end
        wr(4'h0, 8'h66);
        wr(4'hC, 8'h00);
        rd(4'h0, rv); check("R13 ptr kept lo", 32'(rv), 32'h77);
        rd(4'h0, rv); check("R13 ptr kept hi", 32'(rv), 32'h66);
        rd(4'h8, rv); check("R13 tc kept", 32'(rv), 32'h28);
    endtask

    task automatic t_mreset;
        wr(4'hC, 8'h00);
        wr(4'hE, 8'h00);
        wr(4'h9, 8'h07);
        pulse_tc(4'h3);
        wr(4'h2, 8'h3C);
        wr(4'hD, 8'h00);
        check("R10 masks set", 32'(chan_mask), 32'hF);
        check("R10 req cleared", 32'(chan_req), 32'h0);
        rd(4'h8, rv); check("R10 status cleared", 32'(rv), 32'h00);
        rd(4'h2, rv); check("R10 ptr low, word kept", 32'(rv), 32'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_words();
        t_shared();
        t_cmd();
        t_req();
        t_mask();
        t_mode();
        t_status();
        t_noread();
        t_mreset();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule